// File: doc/BRIEF.md
# Mode-selectable PLL feedback divider

This block is the feedback divider of a frequency synthesizer loop. Two oscillator inputs, one for the low band and one for the high band, arrive as single-cycle edge strobes synchronous to the system clock. A 2-bit mode field picks which input is live and how it is divided. The divide is either a plain programmable count N, or a pulse-swallow divide that combines a swallow count A, a programmable count N and an internal dual-modulus prescaler of ratio P or P+1. The result is a one-clock pulse per completed division cycle, which goes to a phase comparator.

The mode lives in a 4-bit register with a simple write strobe and a readback bus. The block drives a pull-down enable for each oscillator input, so an unused input is parked. A warm-clear input restarts the divide chain and leaves the mode untouched, as on a clock-stop or chip-enable event. A status output shows that the comparator, reference and charge-pump path keeps running, including in the mode where both inputs are shut off. The programmable and swallow counts are written to holding registers and are copied into the active counters only at a division boundary.

Top module: `pll_fb_divider`

## Requirements
- R1: Mode code in register bits [1:0]: 2'b01 divides the low-band input directly, 2'b10 pulse-swallows the high-band input, 2'b11 pulse-swallows the low-band input, and 2'b00 divides neither input.
- R2: In direct mode one output pulse is produced for every N edges of the selected input (N ≥ 2).
- R3: In pulse-swallow mode the ratio is N*P+A (P = 32, A < N). The prescaler runs at P+1 for the first A of its output cycles in each division cycle and at P for the rest.
- R4: pd_lo is 1 unless the low-band input is selected (codes 01, 11). pd_hi is 1 unless the high-band input is selected (code 10). In code 00 both are 1.
- R5: In code 00 div_pulse stays 0, while loop_run stays 1 once reset has been released.
- R6: The register reads back 4 bits, with the mode in bits [1:0]. Bits [3:2] always read 0 whatever is written.
- R7: Power-on reset (rst_n low) clears the register to 4'b0000. warm_clr restarts the counters and keeps the register value.
- R8: div_pulse is exactly one clock wide. It is high in the cycle after the clock in which the terminal input edge arrived.
- R9: Values written to the N and A holding registers take effect only when the current division cycle ends, or on a restart.
- R10: A register write that changes the mode code restarts the prescaler and both counters. Input edges in the cycle of that write are not counted.
- R11: Edges on the input that is not selected have no effect on the output pulse stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous active-low, released synchronously |
| warm_clr | input | 1 | Restart of the divide chain that keeps the mode register |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 4 | Mode register write data |
| reg_rdata | output | 4 | Mode register readback |
| cnt_we | input | 1 | Holding register write strobe for N and A |
| n_wdata | input | N_W | Programmable count N |
| a_wdata | input | A_W | Swallow count A |
| osc_lo_edge | input | 1 | Low-band oscillator edge strobe |
| osc_hi_edge | input | 1 | High-band oscillator edge strobe |
| div_pulse | output | 1 | Divided output pulse to the phase comparator |
| pd_lo | output | 1 | Pull-down enable, low-band input |
| pd_hi | output | 1 | Pull-down enable, high-band input |
| loop_run | output | 1 | Comparator, reference and charge-pump path enabled |

## Verification
The pulse-isolation property assumes that the active ratio is never 1. This means N ≥ 2 in direct mode, while in swallow mode P alone keeps the ratio large. The bench therefore draws direct-mode N from 2 to 60, swallow-mode N from 1 to 12, and A strictly below N. Every mode change or count reload is done with both edge strobes held low, and a warm clear follows so that each window starts from a known count. During the windows the unselected input is driven with its own random strobes, so R11 is covered by the same pulse-count comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int NUM_OSC = 2;
  localparam int OSC_LO  = 0;
  localparam int OSC_HI  = 1;
  localparam int REG_W   = 4;
  localparam int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF       = 2'b00,
    MODE_DIRECT_LO = 2'b01,
    MODE_SWAL_HI   = 2'b10,
    MODE_SWAL_LO   = 2'b11
  } fb_mode_e;
endpackage

// File: rtl/pfd_mode_reg.sv
module pfd_mode_reg
  import pfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output fb_mode_e         mode,
  output logic             mode_chg
);
  localparam logic [REG_W-1:0] WR_MASK = REG_W'((1 << MODE_W) - 1);

  logic [REG_W-1:0] reg_q, reg_d;
  logic             reg_en;

  always_comb begin
    reg_en = wr_en;
    reg_d  = wr_data & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end

  always_comb begin
    rd_data  = reg_q;
    mode     = fb_mode_e'(reg_q[MODE_W-1:0]);
    mode_chg = wr_en && (reg_d[MODE_W-1:0] != reg_q[MODE_W-1:0]);
  end
endmodule

// File: rtl/pfd_prescaler.sv
module pfd_prescaler #(
  parameter int P = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic plus1,
  output logic tc
);
  localparam int PW = $clog2(P + 1);

  logic [PW-1:0] cnt_q, cnt_d, last;
  logic          cnt_en;

  always_comb begin
    last   = plus1 ? PW'(P) : PW'(P - 1);
    tc     = en && !clr && (cnt_q == last);
    cnt_en = clr || en;
    if (clr || tc) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pfd_counters.sv
module pfd_counters #(
  parameter int N_W = 10,
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           direct,
  input  logic           step,
  input  logic           hold_we,
  input  logic [N_W-1:0] n_wdata,
  input  logic [A_W-1:0] a_wdata,
  output logic           swal_active,
  output logic           fire
);
  localparam logic [N_W-1:0] N_RST = N_W'(2);

  logic [N_W-1:0] n_hold_q, n_cur_q, n_cur_d, prog_q, prog_d;
  logic [A_W-1:0] a_hold_q, a_cur_q, a_cur_d, swal_q, swal_d;
  logic           term, run_en, reload;

  // holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_hold_q <= N_RST;
      a_hold_q <= '0;
    end else if (hold_we) begin
      n_hold_q <= n_wdata;
      a_hold_q <= a_wdata;
    end
  end

  always_comb begin
    term        = (prog_q == n_cur_q - 1'b1);
    swal_active = !direct && (swal_q < a_cur_q);
    fire        = step && term && !clr;
    reload      = clr || fire;
    run_en      = clr || step;
    n_cur_d     = n_cur_q;
    a_cur_d     = a_cur_q;
    prog_d      = prog_q;
    swal_d      = swal_q;
    if (reload) begin
      n_cur_d = n_hold_q;
      a_cur_d = a_hold_q;
      prog_d  = '0;
      swal_d  = '0;
    end else begin
      prog_d = prog_q + 1'b1;
      if (swal_active) swal_d = swal_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cur_q <= N_RST;
      a_cur_q <= '0;
      prog_q  <= '0;
      swal_q  <= '0;
    end else if (run_en) begin
      n_cur_q <= n_cur_d;
      a_cur_q <= a_cur_d;
      prog_q  <= prog_d;
      swal_q  <= swal_d;
    end
  end
endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider
  import pfd_pkg::*;
#(
  parameter int P   = 32,
  parameter int N_W = 10,
  parameter int A_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_clr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             cnt_we,
  input  logic [N_W-1:0]   n_wdata,
  input  logic [A_W-1:0]   a_wdata,
  input  logic             osc_lo_edge,
  input  logic             osc_hi_edge,
  output logic             div_pulse,
  output logic             pd_lo,
  output logic             pd_hi,
  output logic             loop_run
);
  logic           rst_meta_q, rst_sync_q;
  fb_mode_e       mode;
  logic           mode_chg, restart, direct, sel_edge;
  logic           presc_tc, step, swal_active, fire, pulse_q;
  logic [NUM_OSC-1:0] osc_sel, osc_edge, pd_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pfd_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (reg_we),
    .wr_data  (reg_wdata),
    .rd_data  (reg_rdata),
    .mode     (mode),
    .mode_chg (mode_chg)
  );

  always_comb begin
    osc_sel[OSC_LO]  = (mode == MODE_DIRECT_LO) || (mode == MODE_SWAL_LO);
    osc_sel[OSC_HI]  = (mode == MODE_SWAL_HI);
    osc_edge[OSC_LO] = osc_lo_edge;
    osc_edge[OSC_HI] = osc_hi_edge;
    direct           = (mode == MODE_DIRECT_LO);
    restart          = warm_clr || mode_chg;
    sel_edge         = |(osc_sel & osc_edge);
    step             = direct ? sel_edge : presc_tc;
  end

  for (genvar gi = 0; gi < NUM_OSC; gi++) begin : g_pd
    assign pd_vec[gi] = !osc_sel[gi];
  end

  pfd_prescaler #(.P(P)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (restart),
    .en    (sel_edge && !direct),
    .plus1 (swal_active),
    .tc    (presc_tc)
  );

  pfd_counters #(.N_W(N_W), .A_W(A_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .clr         (restart),
    .direct      (direct),
    .step        (step),
    .hold_we     (cnt_we),
    .n_wdata     (n_wdata),
    .a_wdata     (a_wdata),
    .swal_active (swal_active),
    .fire        (fire)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) pulse_q <= 1'b0;
    else             pulse_q <= fire;
  end

  always_comb begin
    div_pulse = pulse_q;
    pd_lo     = pd_vec[OSC_LO];
    pd_hi     = pd_vec[OSC_HI];
    loop_run  = rst_sync_q;
  end
endmodule

// File: rtl/pll_fb_divider_chk.sv
module pll_fb_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       warm_clr,
  input logic       reg_we,
  input logic [3:0] reg_rdata,
  input logic       div_pulse,
  input logic       pd_lo,
  input logic       pd_hi
);
  AST_PD_NOT_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_lo || pd_hi)); // R4

  AST_PD_HI_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] == 2'b10) |-> (pd_lo && !pd_hi)); // R4

  AST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] == 2'b00 && $past(reg_rdata[1:0]) == 2'b00) |-> !div_pulse); // R5

  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[3:2] == 2'b00)); // R6

  AST_WARM_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_clr && !reg_we) |=> $stable(reg_rdata)); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R8

  AST_RESTART_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    warm_clr |=> !div_pulse); // R10
endmodule

bind pll_fb_divider pll_fb_divider_chk u_chk (.*);

// File: tb/pll_fb_divider_tb.sv
module pll_fb_divider_tb;
  localparam int P   = 32;
  localparam int N_W = 10;
  localparam int A_W = 5;

  logic           clk = 1'b0;
  logic           rst_n, warm_clr, reg_we, cnt_we, osc_lo_edge, osc_hi_edge;
  logic [3:0]     reg_wdata, reg_rdata;
  logic [N_W-1:0] n_wdata;
  logic [A_W-1:0] a_wdata;
  logic           div_pulse, pd_lo, pd_hi, loop_run;
  int             total = 0, bad = 0;

  always #10 clk = ~clk;

  pll_fb_divider #(.P(P), .N_W(N_W), .A_W(A_W)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(int edges, int r1, int r2);
    if (edges < r1) return 0;
    return 1 + (edges - r1) / r2;
  endfunction

  task automatic wr_mode(logic [3:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wr_cnt(int n, int a);
    @(negedge clk); cnt_we = 1'b1; n_wdata = N_W'(n); a_wdata = A_W'(a);
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic warm();
    @(negedge clk); warm_clr = 1'b1;
    @(negedge clk); warm_clr = 1'b0;
  endtask

  // drives random strobes on both inputs and counts output pulses
  task automatic run(bit on_lo, int cycles, int dens, output int edges, output int pulses);
    edges = 0; pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      logic lo, hi;
      @(negedge clk);
      pulses += int'(div_pulse);
      lo = (($urandom % 100) < dens);
      hi = (($urandom % 100) < dens);
      osc_lo_edge = lo; osc_hi_edge = hi;
      edges += on_lo ? int'(lo) : int'(hi);
    end
    @(negedge clk);
    pulses += int'(div_pulse);
    osc_lo_edge = 1'b0; osc_hi_edge = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      pulses += int'(div_pulse);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e, p, n, a;
    void'($urandom(32'd4242));
    rst_n = 1'b0; warm_clr = 1'b0; reg_we = 1'b0; cnt_we = 1'b0;
    reg_wdata = '0; n_wdata = '0; a_wdata = '0;
    osc_lo_edge = 1'b0; osc_hi_edge = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state, R4 both pull-downs, R5 loop running
    chk("R7 reset rdata", reg_rdata, 0);
    chk("R4 reset pd_lo", pd_lo, 1);
    chk("R4 reset pd_hi", pd_hi, 1);
    chk("R5 loop_run", loop_run, 1);
    chk("R8 reset pulse", div_pulse, 0);

    // R6 upper bits ignore writes
    wr_mode(4'hF);
    chk("R6 upper bits read 0", reg_rdata, 3);
    chk("R4 mode11 pd_lo", pd_lo, 0);
    chk("R4 mode11 pd_hi", pd_hi, 1);

    // R5 mode 00: no pulses on either input
    wr_mode(4'h0);
    run(1'b1, 600, 100, e, p);
    chk("R5 off lo pulses", p, 0);
    run(1'b0, 600, 100, e, p);
    chk("R5 off hi pulses", p, 0);
    chk("R5 off loop_run", loop_run, 1);

    // R8 latency: direct N=3, three back-to-back edges
    wr_mode(4'h1);
    chk("R4 mode01 pd_hi", pd_hi, 1);
    chk("R4 mode01 pd_lo", pd_lo, 0);
    wr_cnt(3, 0);
    warm();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no early pulse", div_pulse, 0);
      osc_lo_edge = 1'b1;
    end
    @(negedge clk); osc_lo_edge = 1'b0;
    chk("R8 pulse after terminal edge", div_pulse, 1);
    @(negedge clk);
    chk("R8 pulse one clock wide", div_pulse, 0);

    // R2 / R11 direct division, random N, hi strobes also driven
    for (int t = 0; t < 5; t++) begin
      n = 2 + int'($urandom % 59);
      wr_cnt(n, 0);
      warm();
      run(1'b1, 2500, 30 + int'($urandom % 70), e, p);
      chk($sformatf("R2 R11 direct N=%0d", n), p, exp_pulses(e, n, n));
    end

    // R3 / R11 swallow on high band
    wr_mode(4'h2);
    chk("R4 mode10 pd_lo", pd_lo, 1);
    chk("R4 mode10 pd_hi", pd_hi, 0);
    for (int t = 0; t < 4; t++) begin
      n = 1 + int'($urandom % 12);
      a = int'($urandom % n);
      wr_cnt(n, a);
      warm();
      run(1'b0, 4000, 50 + int'($urandom % 50), e, p);
      chk($sformatf("R3 R1 swal hi N=%0d A=%0d", n, a), p, exp_pulses(e, n*P + a, n*P + a));
    end

    // R3 swallow on low band, corner A = N-1 and A = 0
    wr_mode(4'h3);
    for (int t = 0; t < 4; t++) begin
      n = 2 + int'($urandom % 11);
      a = (t % 2 == 0) ? n - 1 : 0;
      wr_cnt(n, a);
      warm();
      run(1'b1, 4000, 100, e, p);
      chk($sformatf("R3 R1 swal lo N=%0d A=%0d", n, a), p, exp_pulses(e, n*P + a, n*P + a));
    end

    // R7 warm clear keeps the mode
    warm();
    chk("R7 warm keeps mode", reg_rdata, 3);

    // R9 new N only at the end of the current cycle
    wr_mode(4'h1);
    wr_cnt(7, 0);
    warm();
    run(1'b1, 3, 100, e, p);
    chk("R9 partial count", p, 0);
    wr_cnt(5, 0);
    run(1'b1, 12, 100, e, p);
    chk("R9 deferred load", p, exp_pulses(e, 4, 5));

    // R10 mode change restarts counters
    wr_cnt(5, 0);
    warm();
    run(1'b1, 3, 100, e, p);
    wr_mode(4'h3);
    wr_mode(4'h1);
    run(1'b1, 4, 100, e, p);
    chk("R10 restart no pulse", p, 0);
    run(1'b1, 1, 100, e, p);
    chk("R10 restart fresh count", p, 1);

    // R10 edges in the write cycle are not counted
    wr_mode(4'h3);
    @(negedge clk); reg_we = 1'b1; reg_wdata = 4'h1; osc_lo_edge = 1'b1;
    @(negedge clk); reg_we = 1'b0; osc_lo_edge = 1'b0;
    run(1'b1, 4, 100, e, p);
    chk("R10 write-cycle edge ignored", p, 0);
    run(1'b1, 1, 100, e, p);
    chk("R10 fifth edge fires", p, 1);

    // R7 power-on reset clears the register
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R7 por clears", reg_rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule